// File: doc/BRIEF.md
# Prescaled PWM Timer with Staged Configuration Update

This block is a single-channel pulse-width modulation timer controlled through two 32-bit word registers. A control word holds the run enable, a staging (sync) flag, a spare bit and a five-bit divider exponent. A count word holds a period count and an active-time (phase) count. The counting clock is the input clock divided by a power of two. Each output period lasts the period count in counting ticks. The output is high from the start of each period until the phase count is reached, and low for the rest of the period.

Software changes the divider, period and phase without the output ever running a mix of old and new values. It raises the staging flag first, then writes the new settings, then clears the flag. While the flag is set, writes go only to shadow copies. Clearing the flag moves all of them to the active set in one cycle. The channel then picks the new set up at its next period wrap. A zero period or a zero phase is a forbidden setting, and the output stays low while either is in use.

Top module: `pwm_sync_timer`

## Requirements
- R1: After a synchronous reset both registers read as zero and `pwm_out` is low.
- R2: The control word is at byte offset 0x0 and the count word at offset 0x4. Control bits: 0 run enable, 4 spare, 11 staging flag, 15 exponent bit 0, 19:16 exponent bits 4:1. Count bits: 25:16 period, 9:0 phase. All other bits read as zero. Any other offset reads as zero, and a write to it changes nothing.
- R3: While enabled, each period lasts period x 2^exponent clock cycles. The output is high for the first phase x 2^exponent cycles of each period and low for the remainder. At exponent 0 the counters advance on every clock.
- R4: The exponent is the five-bit value {control[19:16], control[15]}. Values above 24 act as 24.
- R5: When the phase count is equal to or larger than the period count, the output stays high for the whole period.
- R6: While the period count in use or the phase count in use is zero, the output is low.
- R7: While disabled, the output is low and both counters are held at zero. After enabling, the output starts at the first cycle of a new period, one clock after the write.
- R8: While the staging flag is 1, writes to the count word or the exponent fields change only shadow copies. The output keeps its old settings, and reads return the shadow values.
- R9: A control write that clears a set staging flag moves the shadow period, shadow phase and written exponent into the active set in the same cycle.
- R10: A change to the active settings takes effect only when the current period wraps. The period in progress finishes with its old settings.
- R11: The spare bit reads back as written and does not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the written word |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read word |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its default parameters: 10-bit counts, a maximum exponent of 24 and a 4-bit address. With exponents of 0 to 3 and short periods, every part of the output pattern fits in a few dozen cycles, so whole periods can be counted exactly. This makes the behaviour at the wrap, at restart and across a staged commit visible cycle by cycle. The divide-by-2^24 setting is exercised only in the register fields, because a single tick at that setting is far longer than the run.

// File: rtl/pwm_timer_pkg.sv
// Package: register offsets and field positions shared by the PWM timer.
// Assumes a 32-bit word interface with byte offsets.
package pwm_timer_pkg;
    localparam int DATA_W        = 32;
    localparam int OFS_CTRL      = 0;
    localparam int OFS_COUNT     = 4;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SPARE_BIT = 4;
    localparam int CTRL_STAGE_BIT = 11;
    localparam int CTRL_EXPLO_BIT = 15;
    localparam int CTRL_EXPHI_LSB = 16;
    localparam int COUNT_PER_LSB = 16;
    localparam int COUNT_PH_LSB  = 0;
endpackage

// File: rtl/pwm_regs.sv
// Module: control and count registers with shadow staging.
// While the staging flag is set, writes to the count word and the exponent
// fields land in shadow copies only. A control write that clears the flag
// commits the whole shadow set in one cycle. Assumes one access per cycle.
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 10,
    parameter int EXP_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              run_o,
    output logic              stage_o,
    output logic [CNT_W-1:0]  act_period_o,
    output logic [CNT_W-1:0]  act_phase_o,
    output logic [EXP_W-1:0]  act_exp_o
);
    localparam int EXPHI_W = EXP_W - 1;

    logic             run_q, spare_q, stage_q;
    logic [CNT_W-1:0] sh_period_q, sh_phase_q, act_period_q, act_phase_q;
    logic [EXP_W-1:0] sh_exp_q, act_exp_q;
    logic             wr_ctrl, wr_count;
    logic [EXP_W-1:0] wr_exp;
    logic [CNT_W-1:0] wr_period, wr_phase;
    logic [EXP_W-1:0] view_exp;
    logic [CNT_W-1:0] view_period, view_phase;

    // Decode the write strobe and pull fields out of the write word.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
        wr_count  = wr_en && (wr_addr == ADDR_W'(OFS_COUNT));
        wr_exp    = {wr_data[CTRL_EXPHI_LSB +: EXPHI_W], wr_data[CTRL_EXPLO_BIT]};
        wr_period = wr_data[COUNT_PER_LSB +: CNT_W];
        wr_phase  = wr_data[COUNT_PH_LSB +: CNT_W];
    end

    // Register update: direct when not staging, shadow-only while staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= 1'b0;
            spare_q      <= 1'b0;
            stage_q      <= 1'b0;
            sh_period_q  <= '0;
            sh_phase_q   <= '0;
            sh_exp_q     <= '0;
            act_period_q <= '0;
            act_phase_q  <= '0;
            act_exp_q    <= '0;
        end else if (wr_ctrl) begin
            run_q    <= wr_data[CTRL_RUN_BIT];
            spare_q  <= wr_data[CTRL_SPARE_BIT];
            stage_q  <= wr_data[CTRL_STAGE_BIT];
            sh_exp_q <= wr_exp;
            if (!stage_q) begin
                act_exp_q <= wr_exp;
            end else if (!wr_data[CTRL_STAGE_BIT]) begin
                act_exp_q    <= wr_exp;
                act_period_q <= sh_period_q;
                act_phase_q  <= sh_phase_q;
            end
        end else if (wr_count) begin
            sh_period_q <= wr_period;
            sh_phase_q  <= wr_phase;
            if (!stage_q) begin
                act_period_q <= wr_period;
                act_phase_q  <= wr_phase;
            end
        end
    end

    // Read mux: shadow values while staging, active values otherwise.
    always_comb begin
        view_exp    = stage_q ? sh_exp_q    : act_exp_q;
        view_period = stage_q ? sh_period_q : act_period_q;
        view_phase  = stage_q ? sh_phase_q  : act_phase_q;
        rd_data     = '0;
        if (rd_addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[CTRL_RUN_BIT]   = run_q;
            rd_data[CTRL_SPARE_BIT] = spare_q;
            rd_data[CTRL_STAGE_BIT] = stage_q;
            rd_data[CTRL_EXPLO_BIT] = view_exp[0];
            rd_data[CTRL_EXPHI_LSB +: EXPHI_W] = view_exp[EXP_W-1:1];
        end else if (rd_addr == ADDR_W'(OFS_COUNT)) begin
            rd_data[COUNT_PER_LSB +: CNT_W] = view_period;
            rd_data[COUNT_PH_LSB +: CNT_W]  = view_phase;
        end
    end

    assign run_o        = run_q;
    assign stage_o      = stage_q;
    assign act_period_o = act_period_q;
    assign act_phase_o  = act_phase_q;
    assign act_exp_o    = act_exp_q;
endmodule

// File: rtl/pwm_prescale.sv
// Module: power-of-two clock prescaler.
// Issues one tick every 2^exp cycles while running. The exponent saturates at
// EXP_MAX. Counting restarts on each tick and is held at zero while stopped.
module pwm_prescale #(
    parameter int EXP_W   = 5,
    parameter int EXP_MAX = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int PRE_W = (EXP_MAX > 0) ? EXP_MAX : 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [EXP_W-1:0] eff_exp;

    // Build the terminal count 2^eff-1 from the saturated exponent.
    always_comb begin
        eff_exp = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(eff_exp));
        end
        tick_o = run_i && (pre_q == mask);
    end

    // Cycle counter that restarts on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
// Module: period/phase counter and output stage.
// Latches the active settings at each period wrap, and continuously while
// stopped. The output is high while the count is below the phase. A zero
// period or phase in use forces the output low.
module pwm_channel #(
    parameter int CNT_W = 10,
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] act_period_i,
    input  logic [CNT_W-1:0] act_phase_i,
    input  logic [EXP_W-1:0] act_exp_i,
    output logic [EXP_W-1:0] run_exp_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] run_period_o,
    output logic [CNT_W-1:0] run_phase_o,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cnt_q, per_q, ph_q;
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W:0]   cnt_inc;
    logic             wrap;

    // Detect the last tick of the period.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        wrap    = cnt_inc >= {1'b0, per_q};
    end

    // Count ticks and reload the working settings at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
            ph_q  <= '0;
            exp_q <= '0;
        end else if (!run_i || (tick_i && wrap)) begin
            cnt_q <= '0;
            per_q <= act_period_i;
            ph_q  <= act_phase_i;
            exp_q <= act_exp_i;
        end else if (tick_i) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // Output decode from the registered state.
    always_comb begin
        pwm_o = run_i && (per_q != '0) && (ph_q != '0) && (cnt_q < ph_q);
    end

    assign run_exp_o    = exp_q;
    assign cnt_o        = cnt_q;
    assign run_period_o = per_q;
    assign run_phase_o  = ph_q;
endmodule

// File: rtl/pwm_sync_timer.sv
// Module: top of the single-channel prescaled PWM timer.
// Connects the register block, the prescaler and the channel counter.
// Assumes one register access per cycle and a combinational read port.
module pwm_sync_timer
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 10,
    parameter int EXP_W   = 5,
    parameter int EXP_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              pwm_out
);
    logic             run_en, stage_en, tick;
    logic [CNT_W-1:0] act_period, act_phase, run_period, run_phase, cnt;
    logic [EXP_W-1:0] act_exp, run_exp;

    pwm_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXP_W(EXP_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .run_o(run_en), .stage_o(stage_en), .act_period_o(act_period),
        .act_phase_o(act_phase), .act_exp_o(act_exp)
    );

    pwm_prescale #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) i_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run_en), .exp_i(run_exp), .tick_o(tick)
    );

    pwm_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W)) i_chan (
        .clk(clk), .rst_n(rst_n), .run_i(run_en), .tick_i(tick),
        .act_period_i(act_period), .act_phase_i(act_phase), .act_exp_i(act_exp),
        .run_exp_o(run_exp), .cnt_o(cnt), .run_period_o(run_period),
        .run_phase_o(run_phase), .pwm_o(pwm_out)
    );
endmodule

// File: rtl/pwm_sync_timer_chk.sv
// Module: assertion checker bound to the PWM timer top.
// Observes the register outputs and the channel state across modules.
module pwm_sync_timer_chk #(
    parameter int CNT_W = 10,
    parameter int EXP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             stage_en,
    input logic [CNT_W-1:0] act_period,
    input logic [CNT_W-1:0] act_phase,
    input logic [EXP_W-1:0] act_exp,
    input logic [CNT_W-1:0] run_period,
    input logic [CNT_W-1:0] run_phase,
    input logic [CNT_W-1:0] cnt,
    input logic             pwm_out
);
    // R7: a stopped channel drives low.
    a_r7_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !pwm_out);

    // R6: a high output never comes from a zero period or phase.
    a_r6_forbidden_low: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> (run_period != '0 && run_phase != '0));

    // R8: the active set holds while staging stays on.
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en && $past(stage_en)) |->
            ($stable(act_period) && $stable(act_phase) && $stable(act_exp)));

    // R10: settings in use change only at the start of a period.
    a_r10_reload_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en) && !$stable(run_period)) |-> (cnt == '0));

    // R3: the count stays inside the period.
    a_r3_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && run_period != '0) |-> (cnt < run_period));
endmodule

bind pwm_sync_timer pwm_sync_timer_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .stage_en(stage_en),
    .act_period(act_period), .act_phase(act_phase), .act_exp(act_exp),
    .run_period(run_period), .run_phase(run_phase), .cnt(cnt), .pwm_out(pwm_out)
);

// File: tb/test_pwm_sync_timer.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared every cycle, plus directed checks.
module test_pwm_sync_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_sync_timer i_pwm_sync_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    // Reference state
    longint m_run, m_spare, m_stage, m_shp, m_shph, m_she, m_ap, m_aph, m_ae;
    longint m_rp, m_rph, m_re, m_cnt, m_pre;
    initial begin
        m_run = 0; m_spare = 0; m_stage = 0; m_shp = 0; m_shph = 0; m_she = 0;
        m_ap = 0; m_aph = 0; m_ae = 0; m_rp = 0; m_rph = 0; m_re = 0; m_cnt = 0; m_pre = 0;
    end

    function automatic logic [31:0] m_read(input int a);
        longint e, p, ph;
        if (a == 0) begin
            e = m_stage ? m_she : m_ae;
            return 32'(m_run | (m_spare << 4) | (m_stage << 11) | ((e & 1) << 15) | ((e >> 1) << 16));
        end else if (a == 4) begin
            p = m_stage ? m_shp : m_ap;
            ph = m_stage ? m_shph : m_aph;
            return 32'((p << 16) | ph);
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        longint eff, n_cnt, n_pre, n_rp, n_rph, n_re, we, d;
        bit tick;
        if (!rst_n) begin
            m_run = 0; m_spare = 0; m_stage = 0; m_shp = 0; m_shph = 0; m_she = 0;
            m_ap = 0; m_aph = 0; m_ae = 0; m_rp = 0; m_rph = 0; m_re = 0; m_cnt = 0; m_pre = 0;
        end else begin
            eff = (m_re > 24) ? 24 : m_re;
            tick = (m_run != 0) && (m_pre == ((64'd1 << eff) - 1));
            n_cnt = m_cnt; n_pre = m_pre; n_rp = m_rp; n_rph = m_rph; n_re = m_re;
            if (m_run == 0) begin
                n_cnt = 0; n_pre = 0; n_rp = m_ap; n_rph = m_aph; n_re = m_ae;
            end else if (tick) begin
                n_pre = 0;
                if (m_cnt + 1 >= m_rp) begin
                    n_cnt = 0; n_rp = m_ap; n_rph = m_aph; n_re = m_ae;
                end else n_cnt = m_cnt + 1;
            end else n_pre = m_pre + 1;
            m_cnt = n_cnt; m_pre = n_pre; m_rp = n_rp; m_rph = n_rph; m_re = n_re;
            d = longint'(wr_data);
            if (wr_en && wr_addr == 0) begin
                we = (((d >> 16) & 15) << 1) | ((d >> 15) & 1);
                m_she = we;
                if (m_stage == 0) m_ae = we;
                else if (((d >> 11) & 1) == 0) begin
                    m_ae = we; m_ap = m_shp; m_aph = m_shph;
                end
                m_run = d & 1; m_spare = (d >> 4) & 1; m_stage = (d >> 11) & 1;
            end else if (wr_en && wr_addr == 4) begin
                m_shp = (d >> 16) & 1023; m_shph = d & 1023;
                if (m_stage == 0) begin m_ap = m_shp; m_aph = m_shph; end
            end
        end
    end

    // Every-cycle comparison against the reference (R3 R9 R10 waveform, R2 R8 reads).
    always @(negedge clk) begin
        logic exp_out;
        logic [31:0] exp_rd;
        if (rst_n && !done) begin
            exp_out = (m_run != 0) && (m_rp != 0) && (m_rph != 0) && (m_cnt < m_rph);
            exp_rd = m_read(int'(rd_addr));
            checks++;
            if (pwm_out !== exp_out) begin
                errors++;
                $display("FAIL R3 R10 cycle output: actual %0b expected %0b at %0t", pwm_out, exp_out, $time);
            end
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL R2 R8 cycle read: actual %08h expected %08h at %0t", rd_data, exp_rd, $time);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] expv);
        rd_addr = a;
        #1;
        check(req, rd_data, expv);
    endtask

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_check("R1 ctrl after reset", 4'h0, 32'h0);
        rd_check("R1 count after reset", 4'h4, 32'h0);
        check("R1 output after reset", pwm_out, 0);

        // R2: field map and unused offsets
        wr(4'h0, 32'hFFFF_FFFE);
        rd_check("R2 ctrl fields", 4'h0, 32'h000F_8810);
        wr(4'h4, 32'hFFFF_FFFF);
        rd_check("R2 count fields", 4'h4, 32'h03FF_03FF);
        wr(4'h0, 32'h0);
        rd_check("R2 ctrl cleared", 4'h0, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF);
        rd_check("R2 unused offset reads zero", 4'h8, 32'h0);
        rd_check("R2 unused write ignored", 4'h4, 32'h03FF_03FF);

        // R3: exponent 0, period 10, phase 3
        wr(4'h4, 32'h000A_0003);
        wr(4'h0, 32'h0000_0001);
        count_high(30, hi);
        check("R3 duty exp0", hi, 9);

        // R7: stop then restart
        wr(4'h0, 32'h0);
        count_high(5, hi);
        check("R7 low while stopped", hi, 0);
        wr(4'h0, 32'h1);
        count_high(3, hi);
        check("R7 restart high from period start", hi, 3);
        count_high(7, hi);
        check("R7 restart low remainder", hi, 0);

        // R3 R4: exponent 2 (field 0x1 in 19:16), period 4 phase 1
        wr(4'h0, 32'h0001_0000);
        wr(4'h4, 32'h0004_0001);
        wr(4'h0, 32'h0001_0001);
        count_high(4, hi);
        check("R3 R4 exp2 high part", hi, 4);
        count_high(28, hi);
        check("R3 R4 exp2 rest", hi, 4);

        // R4: exponent 3 uses the low bit 15
        wr(4'h0, 32'h0001_8000);
        wr(4'h4, 32'h0002_0001);
        wr(4'h0, 32'h0001_8001);
        count_high(32, hi);
        check("R4 exp3 duty", hi, 16);

        // R5: phase above and equal to period
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0005_0007);
        wr(4'h0, 32'h1);
        count_high(20, hi);
        check("R5 phase above period", hi, 20);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0005_0005);
        wr(4'h0, 32'h1);
        count_high(20, hi);
        check("R5 phase equal period", hi, 20);

        // R6: forbidden zero settings
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0000_0003);
        wr(4'h0, 32'h1);
        count_high(20, hi);
        check("R6 zero period", hi, 0);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0004_0000);
        wr(4'h0, 32'h1);
        count_high(20, hi);
        check("R6 zero phase", hi, 0);

        // R10: unstaged change mid-period finishes the current period first
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h000A_0005);
        wr(4'h0, 32'h1);
        count_high(2, hi);
        wr(4'h4, 32'h0004_0002);
        count_high(6, hi);
        check("R10 old period completes", hi, 1);
        count_high(4, hi);
        check("R10 new period after wrap", hi, 2);

        // R8 R9: staged update
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h000A_0005);
        wr(4'h0, 32'h1);
        wr(4'h0, 32'h0000_0801);
        wr(4'h4, 32'h0006_0001);
        rd_check("R8 shadow count read", 4'h4, 32'h0006_0001);
        rd_check("R8 staging flag read", 4'h0, 32'h0000_0801);
        count_high(40, hi);
        check("R8 output keeps old setting", hi, 20);
        wr(4'h0, 32'h0000_0001);
        rd_check("R9 committed count read", 4'h4, 32'h0006_0001);
        count_high(10, hi);
        count_high(36, hi);
        check("R9 committed setting in use", hi, 6);

        // R11: spare bit has no effect
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h000A_0005);
        wr(4'h0, 32'h0000_0011);
        rd_check("R11 spare bit reads back", 4'h0, 32'h0000_0011);
        count_high(40, hi);
        check("R11 spare bit no effect", hi, 20);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule